// File: doc/BRIEF.md
# Interrupt priority shift stack

This block holds the processor's interrupt priority as a short history instead of one value. An 8-bit register is split into four 2-bit fields. The low field is the level in force, and the three above it are the levels that were in force earlier. Setting a level shifts the history up and drops the oldest field. Restoring rotates the history back down, so the field just left comes around to the top. A second register of the same shape records system or user mode, with the same shift-in and rotate-out behaviour.

The block takes the second byte of an escape-prefixed opcode, along with a valid strobe, and decodes it. It accepts at most one command per cycle. Commands that move a byte to or from the stack use a simple byte request/acknowledge port and an internal stack pointer, and they hold `busy` until their transfers finish. A return from interrupt pops the saved priority byte and then a two-byte return address, which the block hands back through `ret_addr` with a one-cycle `ret_valid` strobe. Reading the mode copies the user bit into the carry position of a flags byte that the core supplies.

Top module: `ipri_shift_stack`

## Requirements
- R1: After reset, `pri_stack` and `mode_stack` are 0x00 (priority 0, system mode), `busy`, `mem_req`, `flags_we` and `ret_valid` are 0, and `sp` equals the parameter `SP_INIT` (default 0x0080).
- R2: An accepted opcode of 0x46, 0x4E, 0x56 or 0x5E sets the priority to opcode bits [4:3] (levels 0, 1, 2, 3). From the next cycle `pri_stack` equals the old bits [5:0] followed by the level in bits [1:0]. `cur_pri` always equals `pri_stack[1:0]`.
- R3: An accepted opcode 0x5D rotates `pri_stack` right by two bits, so the old bits [1:0] appear in bits [7:6].
- R4: An accepted opcode 0x76 decrements `sp` by one and then writes the whole `pri_stack` byte to the new `sp` address (`mem_we`=1).
- R5: An accepted opcode 0x7E reads the byte at `sp` into `pri_stack` and then increments `sp` by one.
- R6: An accepted opcode 0x4D reads the priority byte at `sp`, then the return address low byte at `sp`+1 and the high byte at `sp`+2. `sp` ends three higher, and `ret_valid` pulses for exactly one cycle with `ret_addr` = {high, low}, in the same cycle that `busy` falls.
- R7: An accepted opcode 0x6F shifts `mode_stack` left by two and puts 01 in bits [1:0]. `cur_mode` always equals `mode_stack[1:0]`.
- R8: An accepted opcode 0x7D rotates `mode_stack` right by two bits.
- R9: An accepted opcode 0x7F makes `flags_we` high for one cycle, with `flags_out` equal to the `flags_in` value it was sampled from, except bit 0 (carry), which is set to `mode_stack[0]`.
- R10: Opcode 0x66 pushes `mode_stack` in the same way as R4, and opcode 0x6E pops it in the same way as R5.
- R11: A command presented while `busy` is high is ignored. So is any opcode not listed in R2 to R10. Neither changes either register, `sp`, or the memory port.
- R12: A memory transfer completes in a cycle where `mem_req` and `mem_ack` are both high. Until then `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Opcode byte that follows the escape prefix |
| flags_in | input | 8 | Current flags byte from the core |
| busy | output | 1 | A stack command is in progress |
| cur_pri | output | 2 | Priority level in force |
| cur_mode | output | 2 | Mode field in force (01 = user) |
| pri_stack | output | 8 | Full priority history register |
| mode_stack | output | 8 | Full mode history register |
| flags_out | output | 8 | Flags byte with carry updated by read-mode |
| flags_we | output | 1 | One-cycle strobe for `flags_out` |
| sp | output | 16 | Stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| ret_valid | output | 1 | Return address valid strobe |
| ret_addr | output | 16 | Popped return address |

## Verification
The assertions check the following in every cycle: the shift and rotate results of the set, restore, user-entry and read-mode commands, the one-step stack pointer moves of push and pop, and the stability of a pending memory request. They also check that commands arriving while busy leave both registers untouched, and that the return strobe lasts one cycle. Some behaviour needs the bench scenarios with a modelled memory at several latencies. This covers which bytes a push places at which address, and the values a pop or return restores. It also covers the three-byte order of the interrupt return and the assembled return address. Unlisted opcodes are shown to be ignored only by inspecting the ports afterwards.

// File: rtl/ipri_pkg.sv
package ipri_pkg;

  localparam logic [7:0] OP_SETPRI0 = 8'h46;
  localparam logic [7:0] OP_SETPRI1 = 8'h4E;
  localparam logic [7:0] OP_SETPRI2 = 8'h56;
  localparam logic [7:0] OP_SETPRI3 = 8'h5E;
  localparam logic [7:0] OP_RESPRI  = 8'h5D;
  localparam logic [7:0] OP_PUSHPRI = 8'h76;
  localparam logic [7:0] OP_POPPRI  = 8'h7E;
  localparam logic [7:0] OP_RETI    = 8'h4D;
  localparam logic [7:0] OP_SETUSR  = 8'h6F;
  localparam logic [7:0] OP_RESMODE = 8'h7D;
  localparam logic [7:0] OP_RDMODE  = 8'h7F;
  localparam logic [7:0] OP_PUSHMOD = 8'h66;
  localparam logic [7:0] OP_POPMOD  = 8'h6E;

  typedef enum logic [3:0] {
    C_NONE, C_SETPRI, C_RESPRI, C_PUSHPRI, C_POPPRI, C_RETI,
    C_SETUSR, C_RESMODE, C_RDMODE, C_PUSHMOD, C_POPMOD
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    cmd_e c;
    case (op)
      OP_SETPRI0, OP_SETPRI1,
      OP_SETPRI2, OP_SETPRI3: c = C_SETPRI;
      OP_RESPRI:              c = C_RESPRI;
      OP_PUSHPRI:             c = C_PUSHPRI;
      OP_POPPRI:              c = C_POPPRI;
      OP_RETI:                c = C_RETI;
      OP_SETUSR:              c = C_SETUSR;
      OP_RESMODE:             c = C_RESMODE;
      OP_RDMODE:              c = C_RDMODE;
      OP_PUSHMOD:             c = C_PUSHMOD;
      OP_POPMOD:              c = C_POPMOD;
      default:                c = C_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ipri_decode.sv
module ipri_decode
  import ipri_pkg::*;
#(
  parameter int FIELD_W = 2
) (
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_op,
  input  logic               busy,
  output cmd_e               cmd,
  output logic [FIELD_W-1:0] level
);

  always_comb begin
    cmd   = C_NONE;
    level = FIELD_W'(cmd_op[4:3]);
    if (cmd_valid && !busy)
      cmd = decode_op(cmd_op);
  end

endmodule

// File: rtl/ipri_field_stack.sv
module ipri_field_stack #(
  parameter int FIELD_W = 2,
  parameter int LEVELS  = 4,
  localparam int W      = FIELD_W * LEVELS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [FIELD_W-1:0] shift_val,
  input  logic               rot_en,
  input  logic               load_en,
  input  logic [W-1:0]       load_val,
  output logic [W-1:0]       q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load_en)
      q <= load_val;
    else if (shift_en)
      q <= {q[W-FIELD_W-1:0], shift_val};
    else if (rot_en)
      q <= {q[FIELD_W-1:0], q[W-1:FIELD_W]};
  end

endmodule

// File: rtl/ipri_stack_seq.sv
module ipri_stack_seq #(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter logic [AW-1:0] SP_INIT = 16'h0080,
  localparam int         RW      = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_push,
  input  logic          start_pop,
  input  logic          start_reti,
  input  logic          pop_to_mode,
  input  logic [DW-1:0] push_byte,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic [AW-1:0] sp,
  output logic          load_pri,
  output logic          load_mode,
  output logic [DW-1:0] load_byte,
  output logic          ret_valid,
  output logic [RW-1:0] ret_addr
);

  typedef enum logic [2:0] {Q_IDLE, Q_WR, Q_POP, Q_RLO, Q_RHI} st_e;
  st_e  st;
  logic tgt_mode;
  logic is_reti;

  assign busy      = (st != Q_IDLE);
  assign load_byte = mem_rdata;
  assign load_pri  = (st == Q_POP) && mem_ack && !tgt_mode;
  assign load_mode = (st == Q_POP) && mem_ack && tgt_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= Q_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      sp        <= SP_INIT;
      ret_valid <= 1'b0;
      ret_addr  <= '0;
      tgt_mode  <= 1'b0;
      is_reti   <= 1'b0;
    end else begin
      ret_valid <= 1'b0;
      case (st)
        Q_IDLE: begin
          if (start_push) begin
            sp        <= sp - 1'b1;
            mem_addr  <= sp - 1'b1;
            mem_wdata <= push_byte;
            mem_we    <= 1'b1;
            mem_req   <= 1'b1;
            st        <= Q_WR;
          end else if (start_pop || start_reti) begin
            mem_addr  <= sp;
            mem_we    <= 1'b0;
            mem_req   <= 1'b1;
            tgt_mode  <= pop_to_mode;
            is_reti   <= start_reti;
            st        <= Q_POP;
          end
        end
        Q_WR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= Q_IDLE;
          end
        end
        Q_POP: begin
          if (mem_ack) begin
            sp <= sp + 1'b1;
            if (is_reti) begin
              mem_addr <= sp + 1'b1;
              st       <= Q_RLO;
            end else begin
              mem_req <= 1'b0;
              st      <= Q_IDLE;
            end
          end
        end
        Q_RLO: begin
          if (mem_ack) begin
            ret_addr[DW-1:0] <= mem_rdata;
            sp               <= sp + 1'b1;
            mem_addr         <= sp + 1'b1;
            st               <= Q_RHI;
          end
        end
        Q_RHI: begin
          if (mem_ack) begin
            ret_addr[RW-1:DW] <= mem_rdata;
            sp                <= sp + 1'b1;
            mem_req           <= 1'b0;
            ret_valid         <= 1'b1;
            st                <= Q_IDLE;
          end
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ipri_shift_stack.sv
module ipri_shift_stack
  import ipri_pkg::*;
#(
  parameter int            FIELD_W   = 2,
  parameter int            LEVELS    = 4,
  parameter int            AW        = 16,
  parameter int            CARRY_BIT = 0,
  parameter logic [AW-1:0] SP_INIT   = 16'h0080,
  localparam int           DW        = FIELD_W * LEVELS,
  localparam int           RW        = 2 * DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_op,
  input  logic [DW-1:0]      flags_in,
  output logic               busy,
  output logic [FIELD_W-1:0] cur_pri,
  output logic [FIELD_W-1:0] cur_mode,
  output logic [DW-1:0]      pri_stack,
  output logic [DW-1:0]      mode_stack,
  output logic [DW-1:0]      flags_out,
  output logic               flags_we,
  output logic [AW-1:0]      sp,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata,
  output logic               ret_valid,
  output logic [RW-1:0]      ret_addr
);

  localparam int NSTK = 2;
  localparam int PRI  = 0;
  localparam int MODE = 1;

  cmd_e               cmd;
  logic [FIELD_W-1:0] level;
  logic               load_pri, load_mode;
  logic [DW-1:0]      load_byte;

  logic [NSTK-1:0]    shift_en, rot_en, load_en;
  logic [FIELD_W-1:0] shift_val [NSTK];
  logic [DW-1:0]      stk_q     [NSTK];

  ipri_decode #(.FIELD_W(FIELD_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .cmd       (cmd),
    .level     (level)
  );

  always_comb begin
    shift_en[PRI]   = (cmd == C_SETPRI);
    rot_en[PRI]     = (cmd == C_RESPRI);
    load_en[PRI]    = load_pri;
    shift_val[PRI]  = level;
    shift_en[MODE]  = (cmd == C_SETUSR);
    rot_en[MODE]    = (cmd == C_RESMODE);
    load_en[MODE]   = load_mode;
    shift_val[MODE] = FIELD_W'(1);
  end

  for (genvar g = 0; g < NSTK; g++) begin : gen_stk
    ipri_field_stack #(.FIELD_W(FIELD_W), .LEVELS(LEVELS)) u_stk (
      .clk       (clk),
      .rst       (rst),
      .shift_en  (shift_en[g]),
      .shift_val (shift_val[g]),
      .rot_en    (rot_en[g]),
      .load_en   (load_en[g]),
      .load_val  (load_byte),
      .q         (stk_q[g])
    );
  end

  assign pri_stack  = stk_q[PRI];
  assign mode_stack = stk_q[MODE];
  assign cur_pri    = pri_stack[FIELD_W-1:0];
  assign cur_mode   = mode_stack[FIELD_W-1:0];

  ipri_stack_seq #(.AW(AW), .DW(DW), .SP_INIT(SP_INIT)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_push  ((cmd == C_PUSHPRI) || (cmd == C_PUSHMOD)),
    .start_pop   ((cmd == C_POPPRI) || (cmd == C_POPMOD)),
    .start_reti  (cmd == C_RETI),
    .pop_to_mode (cmd == C_POPMOD),
    .push_byte   ((cmd == C_PUSHMOD) ? mode_stack : pri_stack),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .busy        (busy),
    .sp          (sp),
    .load_pri    (load_pri),
    .load_mode   (load_mode),
    .load_byte   (load_byte),
    .ret_valid   (ret_valid),
    .ret_addr    (ret_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_out <= '0;
      flags_we  <= 1'b0;
    end else begin
      flags_we <= (cmd == C_RDMODE);
      if (cmd == C_RDMODE) begin
        flags_out            <= flags_in;
        flags_out[CARRY_BIT] <= mode_stack[0];
      end
    end
  end

endmodule

// File: rtl/ipri_checker.sv
module ipri_checker
  import ipri_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [7:0]    cmd_op,
  input logic          busy,
  input logic [DW-1:0] pri_stack,
  input logic [DW-1:0] mode_stack,
  input logic [DW-1:0] flags_out,
  input logic          flags_we,
  input logic [AW-1:0] sp,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          ret_valid
);

  logic take;
  assign take = cmd_valid && !busy;

  p_setpri_r2: assert property (@(posedge clk) disable iff (rst)
    take && (decode_op(cmd_op) == C_SETPRI) |=>
      pri_stack == {$past(pri_stack[DW-3:0]), $past(cmd_op[4:3])});

  p_respri_r3: assert property (@(posedge clk) disable iff (rst)
    take && (cmd_op == OP_RESPRI) |=>
      pri_stack == {$past(pri_stack[1:0]), $past(pri_stack[DW-1:2])});

  p_push_sp_r4: assert property (@(posedge clk) disable iff (rst)
    take && (cmd_op == OP_PUSHPRI) |=> sp == $past(sp) - 1'b1 && mem_req && mem_we);

  p_pop_sp_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !mem_we && !ret_valid && $stable(sp) |=> sp == $past(sp) + 1'b1);

  p_ret_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> !ret_valid);

  p_setusr_r7: assert property (@(posedge clk) disable iff (rst)
    take && (cmd_op == OP_SETUSR) |=> mode_stack == {$past(mode_stack[DW-3:0]), 2'b01});

  p_resmode_r8: assert property (@(posedge clk) disable iff (rst)
    take && (cmd_op == OP_RESMODE) |=>
      mode_stack == {$past(mode_stack[1:0]), $past(mode_stack[DW-1:2])});

  p_rdmode_r9: assert property (@(posedge clk) disable iff (rst)
    take && (cmd_op == OP_RDMODE) |=> flags_we && flags_out[0] == $past(mode_stack[0]));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    busy && !mem_ack |=> $stable(pri_stack) && $stable(mode_stack));

  p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

endmodule

bind ipri_shift_stack ipri_checker #(.AW(AW), .DW(DW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .busy       (busy),
  .pri_stack  (pri_stack),
  .mode_stack (mode_stack),
  .flags_out  (flags_out),
  .flags_we   (flags_we),
  .sp         (sp),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .ret_valid  (ret_valid)
);

// File: tb/ipri_shift_stack_bench.sv
`timescale 1ns/1ps
module ipri_shift_stack_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [7:0]  flags_in = 8'h00;
  logic        busy;
  logic [1:0]  cur_pri, cur_mode;
  logic [7:0]  pri_stack, mode_stack, flags_out, mem_wdata, mem_rdata;
  logic        flags_we, mem_req, mem_we, ret_valid;
  logic        mem_ack = 1'b0;
  logic [15:0] sp, mem_addr, ret_addr;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  int cycles = 0;
  bit done = 0;
  bit saw_ret;
  bit saw_req;
  logic [7:0] mem [256];

  assign mem_rdata = mem[mem_addr[7:0]];

  always #5 clk = ~clk;

  ipri_shift_stack u_ipri_shift_stack (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .flags_in(flags_in), .busy(busy), .cur_pri(cur_pri), .cur_mode(cur_mode),
    .pri_stack(pri_stack), .mode_stack(mode_stack), .flags_out(flags_out),
    .flags_we(flags_we), .sp(sp), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ret_valid(ret_valid), .ret_addr(ret_addr)
  );

  // byte memory model, updated away from the active edge
  always @(negedge clk) begin
    if (mem_req) saw_req = 1'b1;
    if (mem_ack) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      end else cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    saw_ret = 1'b0;
    while (busy) @(negedge clk);
    saw_ret = ret_valid;
  endtask

  task automatic t_reset();
    chk("R1 pri", {8'h0, pri_stack}, 16'h00);
    chk("R1 mode", {8'h0, mode_stack}, 16'h00);
    chk("R1 busy/req/we/ret", {12'h0, busy, mem_req, flags_we, ret_valid}, 16'h0);
    chk("R1 sp", sp, 16'h0080);
  endtask

  task automatic t_set_priority();
    issue(8'h4E); chk("R2 lvl1", {8'h0, pri_stack}, 16'h01);
    issue(8'h56); chk("R2 lvl2", {8'h0, pri_stack}, 16'h06);
    issue(8'h5E); chk("R2 lvl3", {8'h0, pri_stack}, 16'h1B);
    issue(8'h46); chk("R2 lvl0", {8'h0, pri_stack}, 16'h6C);
    issue(8'h5E); chk("R2 top dropped", {8'h0, pri_stack}, 16'hB3);
    chk("R2 cur_pri", {14'h0, cur_pri}, 16'h3);
  endtask

  task automatic t_restore_priority();
    issue(8'h5D); chk("R3 rotate1", {8'h0, pri_stack}, 16'hEC);
    issue(8'h5D); chk("R3 rotate2", {8'h0, pri_stack}, 16'h3B);
  endtask

  task automatic t_mode();
    issue(8'h6F); chk("R7 user1", {8'h0, mode_stack}, 16'h01);
    chk("R7 cur_mode", {14'h0, cur_mode}, 16'h1);
    issue(8'h6F); chk("R7 user2", {8'h0, mode_stack}, 16'h05);
    issue(8'h7D); chk("R8 rotate1", {8'h0, mode_stack}, 16'h41);
    issue(8'h7D); chk("R8 rotate2", {8'h0, mode_stack}, 16'h50);
  endtask

  task automatic t_read_mode();
    flags_in = 8'hFF;
    issue(8'h7F);
    chk("R9 system carry", {7'h0, flags_we, flags_out}, 16'h1FE);
    @(negedge clk);
    chk("R9 strobe one cycle", {15'h0, flags_we}, 16'h0);
    issue(8'h6F);
    flags_in = 8'hA4;
    issue(8'h7F);
    chk("R9 user carry", {7'h0, flags_we, flags_out}, 16'h1A5);
  endtask

  task automatic t_push_pop_priority();
    lat = 2;
    issue(8'h76); wait_idle();
    chk("R4 sp", sp, 16'h007F);
    chk("R4 byte", {8'h0, mem[8'h7F]}, 16'h3B);
    issue(8'h46); chk("R2 before pop", {8'h0, pri_stack}, 16'hEC);
    issue(8'h7E); wait_idle();
    chk("R5 pri", {8'h0, pri_stack}, 16'h3B);
    chk("R5 sp", sp, 16'h0080);
  endtask

  task automatic t_reti();
    lat = 1;
    mem[8'h80] = 8'h9A; mem[8'h81] = 8'h34; mem[8'h82] = 8'h12;
    issue(8'h4D); wait_idle();
    chk("R6 strobe", {15'h0, saw_ret}, 16'h1);
    chk("R6 addr", ret_addr, 16'h1234);
    chk("R6 pri", {8'h0, pri_stack}, 16'h9A);
    chk("R6 sp", sp, 16'h0083);
    @(negedge clk);
    chk("R6 one cycle", {15'h0, ret_valid}, 16'h0);
  endtask

  task automatic t_mode_stack();
    lat = 0;
    issue(8'h66); wait_idle();
    chk("R10 push sp", sp, 16'h0082);
    chk("R10 push byte", {8'h0, mem[8'h82]}, 16'h41);
    issue(8'h6F); chk("R7 before pop", {8'h0, mode_stack}, 16'h05);
    issue(8'h6E); wait_idle();
    chk("R10 pop mode", {8'h0, mode_stack}, 16'h41);
    chk("R10 pop sp", sp, 16'h0083);
  endtask

  task automatic t_busy_ignore();
    lat = 5;
    issue(8'h76);
    cmd_valid = 1'b1; cmd_op = 8'h5E;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h6F;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    chk("R11 pri while busy", {8'h0, pri_stack}, 16'h9A);
    chk("R11 mode while busy", {8'h0, mode_stack}, 16'h41);
    chk("R12 pushed byte", {8'h0, mem[8'h82]}, 16'h9A);
    chk("R12 sp", sp, 16'h0082);
  endtask

  task automatic t_unknown();
    saw_req = 1'b0;
    issue(8'h00);
    issue(8'h45);
    issue(8'hED);
    @(negedge clk);
    chk("R11 unknown pri", {8'h0, pri_stack}, 16'h9A);
    chk("R11 unknown mode", {8'h0, mode_stack}, 16'h41);
    chk("R11 unknown sp", sp, 16'h0082);
    chk("R11 unknown port", {14'h0, saw_req, busy}, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_priority();
    t_restore_priority();
    t_mode();
    t_read_mode();
    t_push_pop_priority();
    t_reti();
    t_mode_stack();
    t_busy_ignore();
    t_unknown();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule